// File: doc/BRIEF.md
# Waveform Timer Channel

This block is one timer channel that generates two digital waveforms. A counter advances on a selected time base, either every clock or once every `PRESCALE` clocks. On each advance it compares the count it is leaving against three programmable values: A, B and C.

Each output reacts to four kinds of event: its own compare (A for output A, B for output B), the C compare, a selectable external edge and a software trigger. Each event carries a 2-bit action code, and a fixed priority settles events that land together. The C compare can restart the count from zero, pause the counter, or switch its clock off. An external edge can also act as a restart.

Software reaches the block through a small word-addressed register port. Reads are combinational. Writes and read side effects take place at the clock edge. A single interrupt line is the OR of the status flags that are selected by an enable register.

Top module: `wave_timer`

## Requirements
- R1: After reset both outputs are low, the count is 0, the clock is off, `irq` is low, and every register reads 0. The register addresses are: 0 command, 1 mode, 2 value A, 3 value B, 4 value C, 5 count, 6 status, 7 interrupt enable.
- R2: Writing command bit 0 turns the clock on and starts counting, and command bit 1 turns it off; turn-off wins when both are written together. With mode bit 0 clear the count advances every cycle. With it set, the count advances once every `PRESCALE` cycles.
- R3: An advance from the all-ones count gives 0 and sets status bit 0.
- R4: An advance that leaves a count equal to A, B or C sets status bit 2, 3 or 4 respectively. Reading address 6 returns the flags and clears status bits 0, 2, 3, 4 and 7, except that an event arriving in that same cycle is kept.
- R5: With mode bit 2 set, a C match loads 0 instead of count+1, so the period is C+1 advances.
- R6: With mode bit 3 set, a C match pauses the counter while status bit 16 (clock on) stays 1.
- R7: With mode bit 4 set, a C match turns the clock off (status bit 16 reads 0). After that a trigger zeroes the count but does not restart it; only command bit 0 does.
- R8: Mode bits [6:5] pick `extIn[n]`. Mode bits [8:7] pick the edge: 01 rising, 10 falling, 11 both, 00 none. A detected edge sets status bit 7.
- R9: With mode bit 9 set, a detected external edge zeroes the count and resumes a paused counter.
- R10: Writing command bit 2 is a software trigger. It zeroes the count, resumes a paused counter, and takes precedence over an advance in the same cycle.
- R11: Mode bit fields map to output actions as follows. Output A uses [11:10] for the A compare, [13:12] for the C compare, [15:14] for the external edge and [17:16] for the software trigger. Output B uses [19:18], [21:20], [23:22] and [25:24] for the same four events. In each field, 01 sets, 10 clears, 11 toggles and 00 leaves the output unchanged.
- R12: When events coincide on one output, the highest-priority event whose code is nonzero takes effect. The priority order is software trigger, then external edge, then C compare, then the output's own compare.
- R13: With mode bit 1 (waveform enable) clear, both outputs hold. Status bits 17 and 18 always mirror output A and output B.
- R14: `irq` is high exactly when some status bit in [7:0] is set and the matching interrupt-enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears the status flags at address 6) |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from address |
| extIn | input | 4 | External event lines |
| outA | output | 1 | Waveform output A |
| outB | output | 1 | Waveform output B |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with an 8-bit counter and a prescale of 3. With these values the wrap from all-ones and its overflow flag come within a few hundred cycles. The divided time base also stays short enough that paused, prescaled and restarted phases all fit in one run. Values A, B and C are set to small numbers, including A equal to C, so that coinciding compares and trigger races occur repeatedly within short windows.

// File: rtl/wave_timer_pkg.sv
package wave_timer_pkg;

  localparam logic [2:0] ADR_CMD   = 3'd0;
  localparam logic [2:0] ADR_MODE  = 3'd1;
  localparam logic [2:0] ADR_VALA  = 3'd2;
  localparam logic [2:0] ADR_VALB  = 3'd3;
  localparam logic [2:0] ADR_VALC  = 3'd4;
  localparam logic [2:0] ADR_COUNT = 3'd5;
  localparam logic [2:0] ADR_STAT  = 3'd6;
  localparam logic [2:0] ADR_IRQEN = 3'd7;

  localparam int ST_OVF   = 0;
  localparam int ST_HITA  = 2;
  localparam int ST_HITB  = 3;
  localparam int ST_HITC  = 4;
  localparam int ST_EXT   = 7;
  localparam int ST_CLKON = 16;
  localparam int ST_LVLA  = 17;
  localparam int ST_LVLB  = 18;

  localparam int MODE_W = 26;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // Field order fixes the bit positions of the mode register.
  typedef struct packed {
    act_e       bSw;
    act_e       bExt;
    act_e       bRc;
    act_e       bCmp;
    act_e       aSw;
    act_e       aExt;
    act_e       aRc;
    act_e       aCmp;
    logic       extRestart;
    logic [1:0] extEdge;
    logic [1:0] extSel;
    logic       rcOff;
    logic       rcPause;
    logic       rcZero;
    logic       waveOn;
    logic       divSel;
  } mode_t;

  typedef struct packed {
    logic tick;
    logic trig;
    logic swEvt;
    logic extEvt;
  } strobe_t;

  typedef struct packed {
    logic cmpA;
    logic cmpB;
    logic cmpC;
    logic ovf;
  } hit_t;

endpackage

// File: rtl/wave_timer_act.sv
module wave_timer_act
  import wave_timer_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic evSw,
  input  logic evExt,
  input  logic evRc,
  input  logic evCmp,
  input  act_e codeSw,
  input  act_e codeExt,
  input  act_e codeRc,
  input  act_e codeCmp,
  output logic lvl
);

  act_e pick;
  logic nxt;

  // Later assignments override earlier ones: lowest priority first.
  always_comb begin
    pick = ACT_KEEP;
    if (evCmp && codeCmp != ACT_KEEP) pick = codeCmp;
    if (evRc  && codeRc  != ACT_KEEP) pick = codeRc;
    if (evExt && codeExt != ACT_KEEP) pick = codeExt;
    if (evSw  && codeSw  != ACT_KEEP) pick = codeSw;
  end

  always_comb begin
    case (pick)
      ACT_SET: nxt = 1'b1;
      ACT_CLR: nxt = 1'b0;
      ACT_TGL: nxt = ~lvl;
      default: nxt = lvl;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   lvl <= 1'b0;
    else if (en) lvl <= nxt;
  end

endmodule

// File: rtl/wave_timer_dp.sv
module wave_timer_dp
  import wave_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  mode_t            mode,
  input  logic [CNT_W-1:0] valA,
  input  logic [CNT_W-1:0] valB,
  input  logic [CNT_W-1:0] valC,
  output logic [CNT_W-1:0] cntVal,
  output hit_t             hits,
  output logic [1:0]       outLvl
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  always_comb begin
    hits.cmpA = strb.tick && (cntVal == valA);
    hits.cmpB = strb.tick && (cntVal == valB);
    hits.cmpC = strb.tick && (cntVal == valC);
    hits.ovf  = strb.tick && (cntVal == CNT_TOP) && !(hits.cmpC && mode.rcZero);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntVal <= '0;
    else if (strb.trig)   cntVal <= '0;
    else if (strb.tick)   cntVal <= (hits.cmpC && mode.rcZero) ? '0 : cntVal + 1'b1;
  end

  for (genvar g = 0; g < 2; g++) begin : g_out
    act_e cSw, cExt, cRc, cCmp;
    logic ownHit;
    if (g == 0) begin : g_chanA
      assign cSw    = mode.aSw;
      assign cExt   = mode.aExt;
      assign cRc    = mode.aRc;
      assign cCmp   = mode.aCmp;
      assign ownHit = hits.cmpA;
    end else begin : g_chanB
      assign cSw    = mode.bSw;
      assign cExt   = mode.bExt;
      assign cRc    = mode.bRc;
      assign cCmp   = mode.bCmp;
      assign ownHit = hits.cmpB;
    end

    wave_timer_act u_act (
      .clk     (clk),
      .rstN    (rstN),
      .en      (mode.waveOn),
      .evSw    (strb.swEvt),
      .evExt   (strb.extEvt),
      .evRc    (hits.cmpC),
      .evCmp   (ownHit),
      .codeSw  (cSw),
      .codeExt (cExt),
      .codeRc  (cRc),
      .codeCmp (cCmp),
      .lvl     (outLvl[g])
    );
  end

endmodule

// File: rtl/wave_timer_ctrl.sv
module wave_timer_ctrl
  import wave_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic [3:0]       extIn,
  input  logic [CNT_W-1:0] cntVal,
  input  hit_t             hits,
  input  logic [1:0]       outLvl,
  output strobe_t          strb,
  output mode_t            modeCfg,
  output logic [CNT_W-1:0] valA,
  output logic [CNT_W-1:0] valB,
  output logic [CNT_W-1:0] valC,
  output logic             clkOn,
  output logic [31:0]      statusVec,
  output logic             irq
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic             running;
  logic [PRE_W-1:0] preCnt;
  logic [3:0]       extPrev;
  logic [7:0]       irqMask;
  logic             fOvf, fHitA, fHitB, fHitC, fExt;

  logic wrCmd, cmdOn, cmdOff, cmdSw, rdStat, going, divHit;
  logic selNow, selOld, extRise, extFall, extEvt, trig;

  always_comb begin
    wrCmd   = regWrEn && (regAddr == ADR_CMD);
    cmdOn   = wrCmd && regWrData[0];
    cmdOff  = wrCmd && regWrData[1];
    cmdSw   = wrCmd && regWrData[2];
    rdStat  = regRdEn && (regAddr == ADR_STAT);
    selNow  = extIn[modeCfg.extSel];
    selOld  = extPrev[modeCfg.extSel];
    extRise = selNow && !selOld;
    extFall = !selNow && selOld;
    extEvt  = (modeCfg.extEdge[0] && extRise) || (modeCfg.extEdge[1] && extFall);
    trig    = cmdSw || (extEvt && modeCfg.extRestart);
    going   = clkOn && running;
    divHit  = !modeCfg.divSel || (preCnt == PRE_LAST);
  end

  always_comb begin
    strb.tick   = going && divHit && !trig;
    strb.trig   = trig;
    strb.swEvt  = cmdSw;
    strb.extEvt = extEvt;
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeCfg <= '0;
      valA    <= '0;
      valB    <= '0;
      valC    <= '0;
      irqMask <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADR_MODE:  modeCfg <= mode_t'(regWrData[MODE_W-1:0]);
        ADR_VALA:  valA    <= regWrData[CNT_W-1:0];
        ADR_VALB:  valB    <= regWrData[CNT_W-1:0];
        ADR_VALC:  valC    <= regWrData[CNT_W-1:0];
        ADR_IRQEN: irqMask <= regWrData[7:0];
        default: ;
      endcase
    end
  end

  // Clock gating state and prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkOn   <= 1'b0;
      running <= 1'b0;
      preCnt  <= '0;
      extPrev <= '0;
    end else begin
      extPrev <= extIn;
      if (cmdOff)                               clkOn <= 1'b0;
      else if (cmdOn)                           clkOn <= 1'b1;
      else if (hits.cmpC && modeCfg.rcOff)      clkOn <= 1'b0;

      if (cmdOn || trig)                        running <= 1'b1;
      else if (hits.cmpC && modeCfg.rcPause)    running <= 1'b0;

      if (trig || !going || !modeCfg.divSel)    preCnt <= '0;
      else if (preCnt == PRE_LAST)              preCnt <= '0;
      else                                      preCnt <= preCnt + 1'b1;
    end
  end

  // Sticky status flags; a fresh event beats a read-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fOvf  <= 1'b0;
      fHitA <= 1'b0;
      fHitB <= 1'b0;
      fHitC <= 1'b0;
      fExt  <= 1'b0;
    end else begin
      fOvf  <= (fOvf  && !rdStat) || hits.ovf;
      fHitA <= (fHitA && !rdStat) || hits.cmpA;
      fHitB <= (fHitB && !rdStat) || hits.cmpB;
      fHitC <= (fHitC && !rdStat) || hits.cmpC;
      fExt  <= (fExt  && !rdStat) || extEvt;
    end
  end

  always_comb begin
    statusVec           = '0;
    statusVec[ST_OVF]   = fOvf;
    statusVec[ST_HITA]  = fHitA;
    statusVec[ST_HITB]  = fHitB;
    statusVec[ST_HITC]  = fHitC;
    statusVec[ST_EXT]   = fExt;
    statusVec[ST_CLKON] = clkOn;
    statusVec[ST_LVLA]  = outLvl[0];
    statusVec[ST_LVLB]  = outLvl[1];
  end

  assign irq = |(statusVec[7:0] & irqMask);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADR_MODE:  regRdData[MODE_W-1:0] = modeCfg;
      ADR_VALA:  regRdData[CNT_W-1:0]  = valA;
      ADR_VALB:  regRdData[CNT_W-1:0]  = valB;
      ADR_VALC:  regRdData[CNT_W-1:0]  = valC;
      ADR_COUNT: regRdData[CNT_W-1:0]  = cntVal;
      ADR_STAT:  regRdData             = statusVec;
      ADR_IRQEN: regRdData[7:0]        = irqMask;
      default:   regRdData             = '0;
    endcase
  end

endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wave_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [3:0]  extIn,
  output logic        outA,
  output logic        outB,
  output logic        irq
);

  strobe_t          strb;
  mode_t            modeCfg;
  hit_t             hits;
  logic [CNT_W-1:0] valA, valB, valC, cntVal;
  logic [1:0]       outLvl;
  logic             clkOn;
  logic [31:0]      statusVec;

  wave_timer_ctrl #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .extIn     (extIn),
    .cntVal    (cntVal),
    .hits      (hits),
    .outLvl    (outLvl),
    .strb      (strb),
    .modeCfg   (modeCfg),
    .valA      (valA),
    .valB      (valB),
    .valC      (valC),
    .clkOn     (clkOn),
    .statusVec (statusVec),
    .irq       (irq)
  );

  wave_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .mode   (modeCfg),
    .valA   (valA),
    .valB   (valB),
    .valC   (valC),
    .cntVal (cntVal),
    .hits   (hits),
    .outLvl (outLvl)
  );

  assign outA = outLvl[0];
  assign outB = outLvl[1];

endmodule

// File: rtl/wave_timer_chk.sv
module wave_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cntVal,
  input logic             clkOn,
  input logic             tickS,
  input logic             trigS,
  input logic             swS,
  input logic             extS,
  input logic             outA,
  input logic             outB,
  input logic             waveOn,
  input logic             flagC,
  input logic             rdStat
);

  // R2: without a trigger the count holds, steps by one or returns to zero
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    !trigS |=> (cntVal == $past(cntVal)) || (cntVal == $past(cntVal) + 1'b1) || (cntVal == '0));

  // R7: clock off and no trigger keeps the count frozen
  a_r7_off_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!clkOn && !trigS) |=> $stable(cntVal));

  // R10: a trigger always leaves a zero count
  a_r10_trig_zero: assert property (@(posedge clk) disable iff (!rstN)
    trigS |=> (cntVal == '0));

  // R11: outputs move only in a cycle that carried some event
  a_r11_quiet_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(tickS || swS || extS) |=> ($stable(outA) && $stable(outB)));

  // R13: waveform disabled keeps both outputs
  a_r13_wave_off_hold: assert property (@(posedge clk) disable iff (!rstN)
    !waveOn |=> ($stable(outA) && $stable(outB)));

  // R4: a compare flag survives until a status read
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagC && !rdStat) |=> flagC);

endmodule

bind wave_timer wave_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .cntVal (cntVal),
  .clkOn  (clkOn),
  .tickS  (strb.tick),
  .trigS  (strb.trig),
  .swS    (strb.swEvt),
  .extS   (strb.extEvt),
  .outA   (outA),
  .outB   (outB),
  .waveOn (modeCfg.waveOn),
  .flagC  (statusVec[4]),
  .rdStat (regRdEn && (regAddr == 3'd6))
);

// File: tb/wave_timer_bench.sv
module wave_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 8;
  localparam int PRE  = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = 3'd5;
  logic [31:0] wdata = '0;
  logic [3:0]  ext = '0;
  logic [31:0] rdData;
  logic        outA, outB, irq;

  int    nChk = 0;
  int    nBad = 0;
  bit    cmpOn = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_timer #(.CNT_W(CW), .PRESCALE(PRE)) u_wave_timer (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn), .regRdEn(rdEn), .regAddr(addr),
    .regWrData(wdata), .regRdData(rdData), .extIn(ext),
    .outA(outA), .outB(outB), .irq(irq)
  );

  // ---------------- reference model ----------------
  int          mCnt, mPre, mRa, mRb, mRc;
  bit          mEn, mRun, mA, mB;
  bit          fOvf, fA, fB, fC, fE;
  logic [25:0] mMode;
  logic [7:0]  mIrqEn;
  logic [3:0]  mPrev;

  function automatic bit actOut(bit cur, bit sw, bit ev, bit rc, bit cmp,
                                logic [1:0] cSw, logic [1:0] cEv, logic [1:0] cRc, logic [1:0] cCmp);
    logic [1:0] c;
    c = 2'b00;
    if (sw && cSw != 2'b00)        c = cSw;
    else if (ev && cEv != 2'b00)   c = cEv;
    else if (rc && cRc != 2'b00)   c = cRc;
    else if (cmp && cCmp != 2'b00) c = cCmp;
    if (c == 2'b01) return 1'b1;
    if (c == 2'b10) return 1'b0;
    if (c == 2'b11) return !cur;
    return cur;
  endfunction

  function automatic logic [31:0] expRd(logic [2:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      3'd1: v[25:0] = mMode;
      3'd2: v = mRa;
      3'd3: v = mRb;
      3'd4: v = mRc;
      3'd5: v = mCnt;
      3'd6: begin
        v[0] = fOvf; v[2] = fA; v[3] = fB; v[4] = fC; v[7] = fE;
        v[16] = mEn; v[17] = mA; v[18] = mB;
      end
      3'd7: v[7:0] = mIrqEn;
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPre = 0; mRa = 0; mRb = 0; mRc = 0;
      mEn = 0; mRun = 0; mA = 0; mB = 0;
      fOvf = 0; fA = 0; fB = 0; fC = 0; fE = 0;
      mMode = '0; mIrqEn = '0; mPrev = '0;
    end else begin
      bit wc, on, off, sw, cur, prv, ev, trg, going, tk, hA, hB, hC, ov, rdS, nEn, nRun;
      logic [1:0] sel, edg;
      wc  = wrEn && addr == 3'd0;
      on  = wc && wdata[0];
      off = wc && wdata[1];
      sw  = wc && wdata[2];
      sel = mMode[6:5];
      edg = mMode[8:7];
      cur = ext[sel];
      prv = mPrev[sel];
      ev  = (edg[0] && cur && !prv) || (edg[1] && !cur && prv);
      trg = sw || (ev && mMode[9]);
      going = mEn && mRun;
      tk  = going && (!mMode[0] || mPre == PRE - 1) && !trg;
      hA  = tk && mCnt == mRa;
      hB  = tk && mCnt == mRb;
      hC  = tk && mCnt == mRc;
      ov  = tk && mCnt == CMAX && !(hC && mMode[2]);
      if (mMode[1]) begin
        mA = actOut(mA, sw, ev, hC, hA, mMode[17:16], mMode[15:14], mMode[13:12], mMode[11:10]);
        mB = actOut(mB, sw, ev, hC, hB, mMode[25:24], mMode[23:22], mMode[21:20], mMode[19:18]);
      end
      if (trg) mCnt = 0;
      else if (tk) mCnt = (hC && mMode[2]) ? 0 : (mCnt + 1) % (CMAX + 1);
      if (trg || !going || !mMode[0]) mPre = 0;
      else mPre = (mPre == PRE - 1) ? 0 : mPre + 1;
      nEn  = off ? 1'b0 : on ? 1'b1 : (hC && mMode[4]) ? 1'b0 : mEn;
      nRun = (on || trg) ? 1'b1 : (hC && mMode[3]) ? 1'b0 : mRun;
      mEn = nEn; mRun = nRun;
      rdS = rdEn && addr == 3'd6;
      if (rdS) begin fOvf = 0; fA = 0; fB = 0; fC = 0; fE = 0; end
      fOvf = fOvf | ov; fA = fA | hA; fB = fB | hB; fC = fC | hC; fE = fE | ev;
      if (wrEn) begin
        case (addr)
          3'd1: mMode  = wdata[25:0];
          3'd2: mRa    = int'(wdata[CW-1:0]);
          3'd3: mRb    = int'(wdata[CW-1:0]);
          3'd4: mRc    = int'(wdata[CW-1:0]);
          3'd7: mIrqEn = wdata[7:0];
          default: ;
        endcase
      end
      mPrev = ext;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      logic [31:0] st;
      st = expRd(3'd6);
      chk({phase, " outA"}, {31'b0, outA}, {31'b0, mA});
      chk({phase, " outB"}, {31'b0, outB}, {31'b0, mB});
      chk({phase, " irq"}, {31'b0, irq}, {31'b0, |(st[7:0] & mIrqEn)});
      chk({phase, " rdData"}, rdData, expRd(addr));
    end
  end

  task automatic finishUp();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  // ---------------- stimulus ----------------
  task automatic tick1();
    @(posedge clk);
    #2;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    tick1();
    wrEn = 1'b0; addr = 3'd5; wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    v = rdData;
    tick1();
    rdEn = 1'b0; addr = 3'd5;
  endtask

  function automatic logic [31:0] mk(bit div, bit wave, bit rcZ, bit rcP, bit rcO,
                                     int sel, int edg, bit extR,
                                     int aCmp, int aRc, int aExt, int aSw,
                                     int bCmp, int bRc, int bExt, int bSw);
    logic [31:0] m;
    m = '0;
    m[0] = div; m[1] = wave; m[2] = rcZ; m[3] = rcP; m[4] = rcO;
    m[6:5] = 2'(sel); m[8:7] = 2'(edg); m[9] = extR;
    m[11:10] = 2'(aCmp); m[13:12] = 2'(aRc); m[15:14] = 2'(aExt); m[17:16] = 2'(aSw);
    m[19:18] = 2'(bCmp); m[21:20] = 2'(bRc); m[23:22] = 2'(bExt); m[25:24] = 2'(bSw);
    return m;
  endfunction

  initial begin
    logic [31:0] v, keepA, keepB;
    run(3);
    rstN = 1'b1;
    cmpOn = 1'b1;

    // R1: reset state
    phase = "R1";
    rd(3'd6, v); chk("R1 status", v, 32'h0);
    rd(3'd1, v); chk("R1 mode", v, 32'h0);
    chk("R1 outA", {31'b0, outA}, 32'h0);

    // R2: every-cycle counting, then prescaled counting
    phase = "R2";
    wr(3'd0, 32'h1);
    run(9);
    wr(3'd0, 32'h2);
    rd(3'd5, v); chk("R2 count after 10 advances", v, 32'd10);
    wr(3'd1, mk(1,0,0,0,0, 0,0,0, 0,0,0,0, 0,0,0,0));
    wr(3'd0, 32'h1);
    run(14);
    wr(3'd0, 32'h3);
    run(3);

    // R3: wrap and overflow flag
    phase = "R3";
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h5);
    run(CMAX + 10);
    rd(3'd6, v); chk("R3 overflow flag", {31'b0, v[0]}, 32'h1);

    // R4: compare flags and read-clear
    phase = "R4";
    wr(3'd2, 32'd5); wr(3'd3, 32'd9); wr(3'd4, 32'd20);
    wr(3'd0, 32'h4);
    run(30);
    rd(3'd6, v); chk("R4 A/B/C flags", v & 32'h1c, 32'h1c);
    rd(3'd6, v); chk("R4 flags cleared", v & 32'h9d, 32'h0);

    // R5: reset on C match
    phase = "R5";
    wr(3'd4, 32'd7);
    wr(3'd1, mk(0,0,1,0,0, 0,0,0, 0,0,0,0, 0,0,0,0));
    wr(3'd0, 32'h4);
    run(30);

    // R6: pause on C match, clock stays on
    phase = "R6";
    wr(3'd1, mk(0,0,1,1,0, 0,0,0, 0,0,0,0, 0,0,0,0));
    wr(3'd0, 32'h4);
    run(20);
    rd(3'd6, v); chk("R6 clock still on", {31'b0, v[16]}, 32'h1);

    // R10: software trigger restarts a paused counter
    phase = "R10";
    wr(3'd0, 32'h4);
    run(5);

    // R7: disable on C match
    phase = "R7";
    wr(3'd1, mk(0,0,0,0,1, 0,0,0, 0,0,0,0, 0,0,0,0));
    wr(3'd0, 32'h4);
    run(20);
    rd(3'd6, v); chk("R7 clock off", {31'b0, v[16]}, 32'h0);
    wr(3'd0, 32'h4);
    run(5);
    rd(3'd5, v); chk("R7 trigger does not restart", v, 32'h0);
    wr(3'd0, 32'h1);
    run(4);

    // R8: external edge selection
    phase = "R8";
    wr(3'd1, mk(0,0,0,0,0, 2,1,0, 0,0,0,0, 0,0,0,0));
    rd(3'd6, v);
    ext = 4'b0001; run(2);
    rd(3'd6, v); chk("R8 wrong line ignored", {31'b0, v[7]}, 32'h0);
    ext = 4'b0101; run(2);
    rd(3'd6, v); chk("R8 rising edge", {31'b0, v[7]}, 32'h1);
    ext = 4'b0001; run(2);
    rd(3'd6, v); chk("R8 falling not selected", {31'b0, v[7]}, 32'h0);
    wr(3'd1, mk(0,0,0,0,0, 2,2,0, 0,0,0,0, 0,0,0,0));
    ext = 4'b0101; run(2);
    ext = 4'b0001; run(2);
    rd(3'd6, v);
    wr(3'd1, mk(0,0,0,0,0, 2,3,0, 0,0,0,0, 0,0,0,0));
    ext = 4'b0101; run(2); ext = 4'b0001; run(2);
    wr(3'd1, mk(0,0,0,0,0, 2,0,0, 0,0,0,0, 0,0,0,0));
    rd(3'd6, v);
    ext = 4'b0101; run(2);
    rd(3'd6, v); chk("R8 no edge selected", {31'b0, v[7]}, 32'h0);
    ext = 4'b0000; run(2);

    // R9: external restart of a paused counter
    phase = "R9";
    wr(3'd4, 32'd4);
    wr(3'd1, mk(0,0,1,1,0, 3,3,1, 0,0,0,0, 0,0,0,0));
    wr(3'd0, 32'h4);
    run(15);
    ext = 4'b1000; run(6);
    ext = 4'b0000; run(10);

    // R11: action codes
    phase = "R11";
    wr(3'd2, 32'd3); wr(3'd3, 32'd5); wr(3'd4, 32'd9);
    wr(3'd1, mk(0,1,1,0,0, 0,0,0, 1,2,0,0, 3,0,0,0));
    wr(3'd0, 32'h4);
    run(40);
    wr(3'd1, mk(1,1,1,0,0, 0,0,0, 1,2,0,3, 3,0,0,1));
    wr(3'd0, 32'h4); run(3);
    wr(3'd0, 32'h4); run(50);

    // R12: priority among coinciding events
    phase = "R12";
    wr(3'd2, 32'd6); wr(3'd4, 32'd6);
    wr(3'd1, mk(0,1,1,0,0, 1,1,0, 2,1,0,0, 0,3,0,0));
    wr(3'd0, 32'h4);
    run(25);
    wr(3'd1, mk(0,1,1,0,0, 1,1,0, 0,0,2,1, 0,0,1,0));
    ext = 4'b0010; wrEn = 1'b1; addr = 3'd0; wdata = 32'h4;
    tick1();
    wrEn = 1'b0; addr = 3'd5; wdata = '0; ext = 4'b0000;
    run(4);
    ext = 4'b0010; run(3); ext = 4'b0000; run(3);

    // R13: waveform disabled, outputs hold
    phase = "R13";
    wr(3'd1, mk(0,0,1,0,0, 1,3,0, 3,3,3,3, 3,3,3,3));
    keepA = {31'b0, outA}; keepB = {31'b0, outB};
    wr(3'd0, 32'h4);
    ext = 4'b0010; run(20); ext = 4'b0000; run(10);
    chk("R13 outA held", {31'b0, outA}, keepA);
    chk("R13 outB held", {31'b0, outB}, keepB);
    rd(3'd6, v); chk("R13 level bits", {30'b0, v[18], v[17]}, {30'b0, keepB[0], keepA[0]});

    // R14: interrupt masking
    phase = "R14";
    rd(3'd6, v);
    wr(3'd7, 32'h10);
    run(15);
    rd(3'd6, v);
    run(2);
    wr(3'd7, 32'h01);
    run(10);
    wr(3'd7, 32'h00);
    run(3);

    finishUp();
  end

endmodule